// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters as asynchronous serial frames on a single output line. A bus-side write puts a character into a holding buffer. A separate shift register sends the frames, so software can queue the next character while the current one is still on the line. The holding buffer moves into the shift register on a bit-clock edge, either when the shifter is idle or during the last bit of the frame in progress. This gives back-to-back frames with no idle gap between them.

The bit clock comes from the system clock in three stages. An optional divide-by-4 comes first, then a divider by (n+1) with an 8-bit n, then a fixed divide-by-16. Two status flags are brought out. One shows that the holding buffer is free. The other shows that the line has gone fully idle after the last stop bit. A single interrupt output pulses when the flag chosen by a select input rises. Each frame takes its format from the configuration inputs at the moment its character enters the shift register.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A frame is a 0 start bit, then 7 data bits (`cfg_len8`=0) or 8 data bits (`cfg_len8`=1) sent least significant bit first, then a parity bit if `cfg_par_en`=1, then one stop bit, or two if `cfg_stop2`=1. Stop bits are 1, and the line idles at 1.
- R2: The parity bit covers only the configured data bits. With `cfg_par_odd`=0, the data bits and the parity bit together hold an even number of ones. With `cfg_par_odd`=1, they hold an odd number.
- R3: `tbuf_empty` is 0 in the cycle after a write. It returns to 1 in the cycle after the buffer moves into the shift register, unless a write arrives in that same cycle.
- R4: `shift_done` rises at the end of the last stop bit of a frame only if no character is waiting. When a character is waiting, the next frame starts at once and `shift_done` stays 0.
- R5: After a write while `shift_done`=1, the start bit begins and `shift_done` falls at the next bit-clock edge. This is between 1 clock and one bit period after the write.
- R6: `tx_irq` is a one-cycle pulse in the cycle after the selected flag goes from 0 to 1. `cfg_irq_sel`=0 selects `tbuf_empty` and `cfg_irq_sel`=1 selects `shift_done`.
- R7: One bit lasts (`cfg_pre4` ? 4 : 1) x (`cfg_div`+1) x 16 clock cycles. Bit-clock edges are counted from reset release, and the first edge comes 15/16 of a period after release.
- R8: A write while `tbuf_empty`=0 replaces the waiting character and leaves the frame on the line unchanged. The replaced character is never sent.
- R9: While reset is held, `txd`=1, `tbuf_empty`=1, `shift_done`=1 and `tx_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pre4 | input | 1 | Divide the clock by 4 ahead of the rate divider |
| cfg_div | input | 8 | Rate divider reload n; divides by n+1 |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_irq_sel | input | 1 | Interrupt source: 0 buffer empty, 1 shift done |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| tbuf_empty | output | 1 | Holding buffer free |
| shift_done | output | 1 | Line idle after the last stop bit |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
Overwriting a waiting character is the hardest case to bring about. It needs two writes that both land while the shifter is still busy with an earlier frame, and after the buffer has already handed that frame over. The stimulus waits for `tbuf_empty` to rise after the first write, then writes twice within a few cycles. At 16 clocks per bit, this is far inside the first frame.

The back-to-back handover is the other hard case. The buffer must be full exactly when the last stop bit ends. The stimulus gets there by writing the second character just after the first one loads.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_MAX = 8;
  localparam int FRAME_W  = DATA_MAX + 4;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   nbits;
  } frame_t;

  function automatic int data_len(fmt_t f);
    return f.len8 ? DATA_MAX : DATA_MAX - 1;
  endfunction

  // parity over the configured data bits only
  function automatic logic parity_of(logic [DATA_MAX-1:0] d, fmt_t f);
    logic p;
    p = f.par_odd;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < data_len(f)) p = p ^ d[i];
    return p;
  endfunction

  // frame image, bit 0 leaves the line first
  function automatic frame_t frame_build(logic [DATA_MAX-1:0] d, fmt_t f);
    frame_t fr;
    int pos;
    fr.bits    = '1;
    fr.bits[0] = 1'b0;
    pos = 1;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < data_len(f)) begin
        fr.bits[pos] = d[i];
        pos = pos + 1;
      end
    end
    if (f.par_en) begin
      fr.bits[pos] = parity_of(d, f);
      pos = pos + 1;
    end
    pos = pos + (f.stop2 ? 2 : 1);
    fr.nbits = CNT_W'(pos);
    return fr;
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int PRE_RATIO = 4,
  parameter int DIV_W     = 8,
  parameter int SUB_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick
);
  localparam int SUB_W = $clog2(SUB_RATIO);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_RATIO - 1);

  logic             src_tick;
  logic             x16_tick;
  logic [DIV_W-1:0] div_cnt;
  logic [SUB_W-1:0] sub_cnt;

  generate
    if (PRE_RATIO > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRE_RATIO);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);
      logic [PRE_W-1:0] pre_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_cnt <= '0;
        else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
        else                       pre_cnt <= pre_cnt + 1'b1;
      end
      assign src_tick = pre_en ? (pre_cnt == PRE_LAST) : 1'b1;
    end else begin : g_nopre
      assign src_tick = 1'b1;
    end
  endgenerate

  assign x16_tick = src_tick && (div_cnt == '0);
  assign bit_tick = x16_tick && (sub_cnt == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (src_tick) div_cnt <= (div_cnt == '0) ? div : div_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_cnt <= '0;
    else if (x16_tick) sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter import uart_tx_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_tick,
  input  logic   load,
  input  frame_t load_frame,
  output logic   txd,
  output logic   ready,
  output logic   frame_end
);
  logic [FRAME_W-1:0] sh_bits;
  logic [CNT_W-1:0]   sh_left;
  logic               busy;

  assign busy      = (sh_left != '0);
  assign ready     = (sh_left <= CNT_W'(1));
  assign frame_end = bit_tick && (sh_left == CNT_W'(1));
  assign txd       = busy ? sh_bits[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_bits <= '1;
      sh_left <= '0;
    end else if (load) begin
      sh_bits <= load_frame.bits;
      sh_left <= load_frame.nbits;
    end else if (bit_tick && busy) begin
      sh_bits <= {1'b1, sh_bits[FRAME_W-1:1]};
      sh_left <= sh_left - 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf import uart_tx_pkg::*; #(
  parameter int PRE_RATIO = 4,
  parameter int DIV_W     = 8,
  parameter int SUB_RATIO = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_pre4,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_len8,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_stop2,
  input  logic                cfg_irq_sel,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  output logic                txd,
  output logic                tbuf_empty,
  output logic                shift_done,
  output logic                tx_irq
);
  logic                bit_tick;
  logic                sh_ready;
  logic                frame_end;
  logic                buf_load;
  logic                buf_full;
  logic [DATA_MAX-1:0] buf_data;
  logic                done_q;
  logic                empty_d;
  logic                done_d;
  logic                irq_q;
  fmt_t                fmt;
  frame_t              next_frame;

  assign fmt        = '{len8: cfg_len8, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign next_frame = frame_build(buf_data, fmt);
  assign buf_load   = bit_tick && buf_full && sh_ready;

  uart_tx_baud #(.PRE_RATIO(PRE_RATIO), .DIV_W(DIV_W), .SUB_RATIO(SUB_RATIO)) u_baud (
    .clk(clk), .rst_n(rst_n), .pre_en(cfg_pre4), .div(cfg_div), .bit_tick(bit_tick)
  );

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(buf_load),
    .load_frame(next_frame), .txd(txd), .ready(sh_ready), .frame_end(frame_end)
  );

  // holding buffer: a write wins over a handover in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (wr_en) begin
      buf_full <= 1'b1;
      buf_data <= wr_data;
    end else if (buf_load) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b1;
    else if (buf_load)  done_q <= 1'b0;
    else if (frame_end) done_q <= 1'b1;
  end

  // interrupt on a rising edge of the chosen flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_d <= 1'b1;
      done_d  <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      empty_d <= ~buf_full;
      done_d  <= done_q;
      irq_q   <= cfg_irq_sel ? (done_q & ~done_d) : (~buf_full & ~empty_d);
    end
  end

  assign tbuf_empty = ~buf_full;
  assign shift_done = done_q;
  assign tx_irq     = irq_q;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic cfg_irq_sel,
  input logic txd,
  input logic tbuf_empty,
  input logic shift_done,
  input logic tx_irq,
  input logic buf_load,
  input logic bit_tick
);
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tbuf_empty);

  a_r3_handover_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_load && !wr_en) |=> tbuf_empty);

  a_r5_load_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> (!txd && !shift_done));

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |-> txd);

  a_r4_done_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_done) |-> $past(bit_tick));

  a_r6_irq_from_source: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> ($past(cfg_irq_sel) ? $past(shift_done) : $past(tbuf_empty)));

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_irq_sel(cfg_irq_sel),
  .txd(txd), .tbuf_empty(tbuf_empty), .shift_done(shift_done), .tx_irq(tx_irq),
  .buf_load(buf_load), .bit_tick(bit_tick)
);

// File: tb/uart_tx_dbuf_bench.sv
`timescale 1ns/1ps
module uart_tx_dbuf_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pre4 = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic cfg_irq_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic txd, tbuf_empty, shift_done, tx_irq;

  int total = 0, bad = 0;
  int per = 16;
  int n_irq = 0, n_done_rise = 0;
  bit prev_done = 1'b1;

  always #5 clk = ~clk;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .cfg_pre4(cfg_pre4), .cfg_div(cfg_div),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_irq_sel(cfg_irq_sel), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tbuf_empty(tbuf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
  );

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_k = 0;
  bit m_q[$];
  bit m_busy = 0, m_full = 0, m_done = 1, m_empty = 1, m_irq = 0;
  bit m_pe = 1, m_pd = 1;
  logic [7:0] m_data = 8'd0;

  function automatic bit ref_tick(int k);
    int j;
    int per16 = per / 16;
    if (cfg_pre4) begin
      if (k % 4 != 3) return 0;
      j = k / 4;
      per16 = per16 / 4;
    end else j = k;
    return (j % (16 * per16)) == 15 * per16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_k = 0; m_q.delete(); m_busy = 0; m_full = 0; m_done = 1; m_empty = 1;
      m_irq = 0; m_pe = 1; m_pd = 1;
    end else begin
      bit tk, last, ld, oe, od, p;
      int nd;
      tk = ref_tick(m_k);
      last = m_busy && m_q.size() == 1;
      ld = tk && m_full && (!m_busy || last);
      oe = m_empty; od = m_done;
      if (tk && m_busy) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_busy = 0;
      end
      if (ld) begin
        m_q.delete();
        m_q.push_back(1'b0);
        nd = cfg_len8 ? 8 : 7;
        p = cfg_par_odd;
        for (int i = 0; i < nd; i++) begin m_q.push_back(m_data[i]); p ^= m_data[i]; end
        if (cfg_par_en) m_q.push_back(p);
        m_q.push_back(1'b1);
        if (cfg_stop2) m_q.push_back(1'b1);
        m_busy = 1;
        m_done = 0;
      end else if (tk && last) m_done = 1;
      if (wr_en) begin m_full = 1; m_data = wr_data; end
      else if (ld) m_full = 0;
      m_empty = !m_full;
      m_irq = cfg_irq_sel ? (od && !m_pd) : (oe && !m_pe);
      m_pe = oe; m_pd = od;
      m_k++;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", txd, m_busy ? m_q[0] : 1'b1, "txd");
      chk("R3", tbuf_empty, m_empty, "tbuf_empty");
      chk("R4", shift_done, m_done, "shift_done");
      chk("R6", tx_irq, m_irq, "tx_irq");
      if (tx_irq) n_irq++;
      if (shift_done && !prev_done) n_done_rise++;
      prev_done = shift_done;
    end
  end

  // ---------------- line receiver ----------------
  logic [7:0] rx_q[$];
  bit rx_on = 0;
  int rx_cnt = 0, rx_nb = 0;
  bit rx_bits[12];

  always @(negedge clk) begin
    if (!rst_n) rx_on = 0;
    else if (!rx_on) begin
      if (txd == 1'b0) begin
        rx_on = 1; rx_cnt = 1;
        rx_nb = 1 + (cfg_len8 ? 8 : 7) + int'(cfg_par_en) + 1 + int'(cfg_stop2);
      end
    end else begin
      if (rx_cnt % per == per / 2) rx_bits[rx_cnt / per] = txd;
      if (rx_cnt == (rx_nb - 1) * per + per / 2) begin
        int nd;
        logic [7:0] d;
        bit p;
        nd = cfg_len8 ? 8 : 7;
        d = 8'd0;
        p = 0;
        for (int i = 0; i < nd; i++) begin d[i] = rx_bits[1 + i]; p ^= rx_bits[1 + i]; end
        chk("R1", rx_bits[0], 0, "start bit");
        if (cfg_par_en) chk("R2", p ^ rx_bits[1 + nd], cfg_par_odd, "parity sum");
        chk("R1", rx_bits[rx_nb - 1], 1, "stop bit");
        rx_q.push_back(d);
        rx_on = 0;
      end
      rx_cnt++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_reset(bit pre, logic [7:0] dv);
    @(negedge clk);
    rst_n = 0; cfg_pre4 = pre; cfg_div = dv;
    per = (pre ? 4 : 1) * (int'(dv) + 1) * 16;
    repeat (3) @(negedge clk);
    chk("R9", txd, 1, "reset txd");
    chk("R9", tbuf_empty, 1, "reset tbuf_empty");
    chk("R9", shift_done, 1, "reset shift_done");
    chk("R9", tx_irq, 0, "reset tx_irq");
    rst_n = 1;
    prev_done = 1;
  endtask

  task automatic write(logic [7:0] b);
    @(negedge clk);
    wr_en = 1; wr_data = b;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tbuf_empty && shift_done));
    repeat (per) @(negedge clk);
  endtask

  task automatic set_fmt(bit l8, bit pe, bit po, bit s2);
    cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  initial begin
    int c;
    logic [7:0] b;
    do_reset(0, 8'd0);
    set_fmt(1, 0, 0, 0);

    // R1/R2: all eight formats
    for (int f = 0; f < 8; f++) begin
      set_fmt(f[0], f[1], f[0] ^ f[2], f[2]);
      b = 8'(8'h3C + f * 37);
      rx_q.delete();
      write(b);
      wait_idle();
      chk("R1", rx_q.size(), 1, "frames seen");
      if (rx_q.size() > 0) chk("R1", rx_q[0], b & (f[0] ? 8'hFF : 8'h7F), "data");
    end

    // R5: start latency from idle
    set_fmt(1, 1, 0, 1);
    write(8'h96);
    c = 0;
    while (shift_done) begin @(negedge clk); c++; end
    chk("R5", (c >= 1 && c <= per) ? 1 : 0, 1, "cycles to start within bit period");
    wait_idle();

    // R8 + R6 (source buffer empty): overwrite a waiting character
    set_fmt(1, 0, 0, 0);
    cfg_irq_sel = 0;
    rx_q.delete(); n_irq = 0; n_done_rise = 0;
    write(8'hA1);
    do @(negedge clk); while (!tbuf_empty);
    write(8'hB2);
    write(8'hC3);
    wait_idle();
    chk("R8", rx_q.size(), 2, "frames after overwrite");
    if (rx_q.size() == 2) begin
      chk("R8", rx_q[0], 8'hA1, "first frame");
      chk("R8", rx_q[1], 8'hC3, "second frame replaces waiting one");
    end
    chk("R6", n_irq, 2, "buffer-empty interrupts");
    chk("R4", n_done_rise, 1, "shift_done rises back-to-back");

    // R6 (source shift done) + R4: back-to-back pair
    cfg_irq_sel = 1;
    set_fmt(0, 1, 1, 1);
    rx_q.delete(); n_irq = 0; n_done_rise = 0;
    write(8'h11);
    do @(negedge clk); while (!tbuf_empty);
    write(8'h7E);
    wait_idle();
    chk("R6", n_irq, 1, "shift-done interrupts");
    chk("R4", n_done_rise, 1, "shift_done rises for pair");
    chk("R1", rx_q.size(), 2, "pair frames");

    // R7: bit period with prescaler and divider
    do_reset(1, 8'd2);
    cfg_irq_sel = 0;
    set_fmt(1, 0, 0, 0);
    write(8'hFF);
    do @(negedge clk); while (txd);
    c = 0;
    while (!txd) begin @(negedge clk); c++; end
    chk("R7", c, 192, "start bit length in clocks");
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule